// File: doc/BRIEF.md
# Clocked One-Shot Pulse Generator

This block turns a chosen transition on an asynchronous trigger line into an output pulse whose length is a programmable number of clock cycles. The trigger is resynchronized on entry, and the edge search runs on the synchronized copy. A polarity input picks whether a rising or a falling transition fires the block.

A mode input picks what happens when another active edge arrives while a pulse is already running. In restart mode the new edge reloads the interval, which stretches the pulse. In lockout mode the new edge is dropped. A synchronous clear ends any pulse at once. The block drives a true output and its complement from two separate registers.

The pulse length comes from a width input. That input is read only at the moment a pulse starts. A width of zero never starts a pulse.

Top module: `pulse_oneshot`

## Requirements
- R1: While reset is asserted, and after it is released with no trigger activity, pulseQ is 0 and pulseQn is 1.
- R2: With edgeFall=0, a 0-to-1 change on trigIn driven between two clock edges makes pulseQ high from the third rising clock edge after that change. It stays high for exactly widthCfg cycles.
- R3: The number of high cycles is the same whether trigIn is held for one cycle or for many cycles.
- R4: With edgeFall=1, a 1-to-0 change on trigIn starts a pulse with the latency given in R2, and a 0-to-1 change starts none. With edgeFall=0, a 1-to-0 change starts none.
- R5: With retrigEn=1, an active edge that lands during a pulse reloads the interval. An edge driven 4 cycles after the first edge, with widthCfg=6, gives 10 high cycles in a row.
- R6: With retrigEn=0, active edges during a pulse are ignored, so the same stimulus as R5 gives 6 high cycles. An edge after the output has returned low starts a fresh pulse.
- R7: clearIn high at a clock edge forces pulseQ low from that edge on. When clearIn is high in the cycle where an active edge would load, no pulse starts.
- R8: widthCfg=0 at the moment an edge is detected produces no pulse.
- R9: Changing widthCfg while a pulse runs does not change that pulse. The next pulse uses the new value.
- R10: pulseQn is the inverse of pulseQ in every cycle.
- R11: Changing edgeFall while trigIn is steady does not start a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 1 | Asynchronous trigger line |
| edgeFall | input | 1 | 0: rising edge active, 1: falling edge active |
| retrigEn | input | 1 | 1: restart mode, 0: lockout mode |
| clearIn | input | 1 | Synchronous clear, ends any pulse |
| widthCfg | input | WIDTH_BITS | Pulse length in clock cycles |
| pulseQ | output | 1 | True pulse output |
| pulseQn | output | 1 | Complement pulse output |

## Verification
A down-counter that loads or decrements wrongly shows up as a pulse one or more cycles too long or too short. A wrong mode decision shows up as a pulse of 10 cycles where 6 are expected, or the reverse. Both are visible within one pulse length of the edge. A broken edge detector either misses a pulse entirely or fires on the wrong polarity, and this appears three cycles after the input change. A complement register that drifts from the true register shows up on the very next cycle as two equal outputs.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // start or restart the interval
    logic clear;  // end the pulse now
  } oneshot_stb_t;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  input  logic fallSel,
  output logic edgeHit
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chainQ;
  logic          prevQ;

  // Resynchronizer chain, one flop per stage
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[g] <= 1'b0;
          else       chainQ[g] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[g] <= 1'b0;
          else       chainQ[g] <= chainQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= chainQ[LAST];
  end

  // Normalizing by polarity makes both edge kinds look like a rise
  logic curN;
  logic prevN;
  always_comb begin
    curN    = chainQ[LAST] ^ fallSel;
    prevN   = prevQ ^ fallSel;
    edgeHit = curN & ~prevN;
  end

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  edgeHit,
  input  logic                  clearIn,
  input  logic                  retrigEn,
  input  logic                  busy,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  output oneshot_stb_t          stb
);
  localparam logic [WIDTH_BITS-1:0] ZERO_W = '0;

  logic widthOk;
  logic acceptEdge;

  always_comb begin
    widthOk    = (widthCfg != ZERO_W);
    acceptEdge = edgeHit & widthOk & (~busy | retrigEn);
    stb.clear  = clearIn;
    // Clear wins over a load in the same cycle
    stb.load   = acceptEdge & ~clearIn;
  end

endmodule

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  oneshot_stb_t          stb,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  output logic                  busy,
  output logic                  pulseQ,
  output logic                  pulseQn
);
  localparam logic [WIDTH_BITS-1:0] CNT_ONE  = WIDTH_BITS'(1);
  localparam logic [WIDTH_BITS-1:0] CNT_ZERO = '0;

  logic [WIDTH_BITS-1:0] remCnt;
  logic                  activeQ;
  logic                  activeNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt   <= CNT_ZERO;
      activeQ  <= 1'b0;
      activeNQ <= 1'b1;
    end else if (stb.clear) begin
      remCnt   <= CNT_ZERO;
      activeQ  <= 1'b0;
      activeNQ <= 1'b1;
    end else if (stb.load) begin
      remCnt   <= widthCfg;
      activeQ  <= 1'b1;
      activeNQ <= 1'b0;
    end else if (activeQ) begin
      if (remCnt == CNT_ONE) begin
        remCnt   <= CNT_ZERO;
        activeQ  <= 1'b0;
        activeNQ <= 1'b1;
      end else begin
        remCnt <= remCnt - CNT_ONE;
      end
    end
  end

  assign busy    = activeQ;
  assign pulseQ  = activeQ;
  assign pulseQn = activeNQ;

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot #(
  parameter int WIDTH_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  trigIn,
  input  logic                  edgeFall,
  input  logic                  retrigEn,
  input  logic                  clearIn,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  output logic                  pulseQ,
  output logic                  pulseQn
);
  import oneshot_pkg::*;

  logic         edgeHit;
  logic         busy;
  oneshot_stb_t stb;

  oneshot_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (trigIn),
    .fallSel (edgeFall),
    .edgeHit (edgeHit)
  );

  oneshot_ctrl #(.WIDTH_BITS(WIDTH_BITS)) ctrl_i (
    .edgeHit  (edgeHit),
    .clearIn  (clearIn),
    .retrigEn (retrigEn),
    .busy     (busy),
    .widthCfg (widthCfg),
    .stb      (stb)
  );

  oneshot_dp #(.WIDTH_BITS(WIDTH_BITS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .widthCfg (widthCfg),
    .busy     (busy),
    .pulseQ   (pulseQ),
    .pulseQn  (pulseQn)
  );

endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int WIDTH_BITS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clearIn,
  input logic                  retrigEn,
  input logic [WIDTH_BITS-1:0] widthCfg,
  input logic                  pulseQ,
  input logic                  pulseQn
);
  logic [31:0]           hiRun;
  logic [WIDTH_BITS-1:0] widthPrev;
  logic [WIDTH_BITS-1:0] startW;
  logic                  pulsePrev;
  logic                  seenRetrig;
  logic [31:0]           curW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun      <= '0;
      widthPrev  <= '0;
      startW     <= '0;
      pulsePrev  <= 1'b0;
      seenRetrig <= 1'b0;
    end else begin
      widthPrev <= widthCfg;
      pulsePrev <= pulseQ;
      hiRun     <= pulseQ ? hiRun + 32'd1 : 32'd0;
      if (pulseQ && !pulsePrev) startW <= widthPrev;
      if (!pulseQ)       seenRetrig <= retrigEn;
      else if (retrigEn) seenRetrig <= 1'b1;
    end
  end

  always_comb begin
    curW = (pulseQ && !pulsePrev) ? 32'(widthPrev) : 32'(startW);
  end

  // R10: complement register never equals the true register
  p_complement_r10: assert property (@(posedge clk) disable iff (!rstN)
    pulseQn != pulseQ);

  // R7: clear ends the pulse at the next edge
  p_clear_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> !pulseQ);

  // R7: no pulse starts at an edge where clear was high
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> !$past(clearIn));

  // R8: a zero width never starts a pulse
  p_zero_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> ($past(widthCfg) != '0));

  // R8: idle output stays idle while the width is zero
  p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseQ && (widthCfg == '0)) |=> !pulseQ);

  // R6: in lockout mode a pulse never outlasts the width it started with
  p_lockout_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ && !seenRetrig && !retrigEn) |-> (hiRun < curW));

endmodule

bind pulse_oneshot oneshot_chk #(.WIDTH_BITS(WIDTH_BITS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .clearIn  (clearIn),
  .retrigEn (retrigEn),
  .widthCfg (widthCfg),
  .pulseQ   (pulseQ),
  .pulseQn  (pulseQn)
);

// File: tb/pulse_oneshot_tb.sv
module pulse_oneshot_tb_top;
  localparam int WB = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          trigIn;
  logic          edgeFall;
  logic          retrigEn;
  logic          clearIn;
  logic [WB-1:0] widthCfg;
  logic          pulseQ;
  logic          pulseQn;

  int checks   = 0;
  int fails    = 0;
  int compErr  = 0;
  int cycIdx   = 0;
  int firstHi  = -1;
  int hiCount  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pulse_oneshot #(.WIDTH_BITS(WB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .edgeFall(edgeFall),
    .retrigEn(retrigEn), .clearIn(clearIn), .widthCfg(widthCfg),
    .pulseQ(pulseQ), .pulseQn(pulseQn)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next falling clock edge and sample the outputs
  task automatic tick();
    @(negedge clk);
    cycIdx++;
    if (pulseQn !== ~pulseQ) compErr++;
    if (pulseQ === 1'b1) begin
      hiCount++;
      if (firstHi < 0) firstHi = cycIdx;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic startMeas();
    cycIdx  = 0;
    firstHi = -1;
    hiCount = 0;
  endtask

  task automatic testReset();
    rstN = 1'b0; trigIn = 1'b0; edgeFall = 1'b0; retrigEn = 1'b0;
    clearIn = 1'b0; widthCfg = 8'd5;
    repeat (3) @(negedge clk);
    check("R1 reset pulseQ", int'(pulseQ), 0);
    check("R1 reset pulseQn", int'(pulseQn), 1);
    rstN = 1'b1;
    startMeas(); ticks(4);
    check("R1 idle after reset", hiCount, 0);
  endtask

  task automatic testRising();
    widthCfg = 8'd5;
    startMeas(); trigIn = 1'b1; ticks(12);
    check("R2 first high cycle", firstHi, 3);
    check("R2 high count", hiCount, 5);
    startMeas(); trigIn = 1'b0; ticks(8);
    check("R4 falling ignored in rising mode", hiCount, 0);
  endtask

  task automatic testHold();
    widthCfg = 8'd5;
    startMeas(); trigIn = 1'b1; tick(); trigIn = 1'b0; ticks(11);
    check("R3 short hold count", hiCount, 5);
    startMeas(); trigIn = 1'b1; ticks(20); trigIn = 1'b0; ticks(4);
    check("R3 long hold count", hiCount, 5);
  endtask

  task automatic testFalling();
    widthCfg = 8'd5;
    startMeas(); edgeFall = 1'b1; ticks(6);
    check("R11 polarity switch no pulse", hiCount, 0);
    startMeas(); trigIn = 1'b1; ticks(8);
    check("R4 rise ignored in falling mode", hiCount, 0);
    startMeas(); trigIn = 1'b0; ticks(10);
    check("R4 falling first high", firstHi, 3);
    check("R4 falling count", hiCount, 5);
    startMeas(); edgeFall = 1'b0; ticks(4);
    check("R11 switch back no pulse", hiCount, 0);
  endtask

  task automatic testRetrig();
    widthCfg = 8'd6; retrigEn = 1'b1;
    startMeas(); trigIn = 1'b1; ticks(2); trigIn = 1'b0; ticks(2);
    trigIn = 1'b1; ticks(16); trigIn = 1'b0; ticks(3);
    check("R5 stretched count", hiCount, 10);
    retrigEn = 1'b0;
  endtask

  task automatic testLockout();
    widthCfg = 8'd6; retrigEn = 1'b0;
    startMeas(); trigIn = 1'b1; ticks(2); trigIn = 1'b0; ticks(2);
    trigIn = 1'b1; ticks(16); trigIn = 1'b0; ticks(3);
    check("R6 lockout count", hiCount, 6);
    startMeas(); trigIn = 1'b1; ticks(10);
    check("R6 new pulse first high", firstHi, 3);
    check("R6 new pulse count", hiCount, 6);
    trigIn = 1'b0; ticks(3);
  endtask

  task automatic testClear();
    widthCfg = 8'd10;
    startMeas(); trigIn = 1'b1; ticks(5); clearIn = 1'b1; tick();
    check("R7 low right after clear", int'(pulseQ), 0);
    clearIn = 1'b0; ticks(12);
    check("R7 cleared count", hiCount, 3);
    trigIn = 1'b0; ticks(4);
    startMeas(); trigIn = 1'b1; ticks(2); clearIn = 1'b1; tick();
    clearIn = 1'b0; ticks(10);
    check("R7 clear beats trigger", hiCount, 0);
    trigIn = 1'b0; ticks(4);
  endtask

  task automatic testZero();
    widthCfg = 8'd0;
    startMeas(); trigIn = 1'b1; ticks(10); trigIn = 1'b0; ticks(3);
    check("R8 zero width count", hiCount, 0);
  endtask

  task automatic testWidthChange();
    widthCfg = 8'd4;
    startMeas(); trigIn = 1'b1; ticks(4); widthCfg = 8'd9; ticks(10);
    check("R9 running pulse keeps width", hiCount, 4);
    trigIn = 1'b0; ticks(3);
    startMeas(); trigIn = 1'b1; ticks(14);
    check("R9 next pulse new width", hiCount, 9);
    trigIn = 1'b0; ticks(3);
  endtask

  initial begin
    testReset();
    testRising();
    testHold();
    testFalling();
    testRetrig();
    testLockout();
    testClear();
    testZero();
    testWidthChange();
    check("R10 complement mismatches", compErr, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule